// File: doc/BRIEF.md
# Compiler-Scheduled Static Mesh Switch

This block is the operand switch that sits in every tile of a two-dimensional mesh of processing tiles. It moves 32-bit words between the four neighbour links (north, east, south, west) and the local processor link. Word headers play no part in routing. A small route program is loaded ahead of time into a local memory. On every cycle the current route word names, for each output, which input feeds it through the crossbar. The switch steps through the program in order and wraps back to the first entry after the last loaded one. One instance models one static network, so a tile with two such networks holds two instances.

Each input lands in a small FIFO, so every link is registered on the receiving side. The ready signal of each input comes straight from that FIFO's occupancy register. A route word executes as a single unit. It fires only when every source it names holds a word and every destination it names is ready. In that cycle the named outputs present their words, and each source is popped exactly once, however many outputs it feeds. If any part is missing, nothing moves and the program counter holds. Because of this, an output's valid signal marks a transfer that completes in that cycle, and it is never raised while the receiver's ready is low.

Top module: `static_mesh_switch`

## Requirements
- R1: After reset the program counter is zero, the program length is zero, every input FIFO is empty (all `in_ready` bits high), and no `out_valid` bit is set.
- R2: Port index order is N=0, E=1, S=2, W=3, P=4. The route word holds one 3-bit field per output, at bits [3*o+2:3*o] for output index o. Code 0 means the output is unused. Codes 1 to 5 select input N, E, S, W or P, and codes 6 and 7 count as unused. A used output carries the head word of its selected input.
- R3: A route word commits only when every named source FIFO holds a word and every named output's `out_ready` is high. Otherwise no FIFO is popped, no `out_valid` is raised, and the program counter holds.
- R4: A source named by several outputs in one route word is delivered to all of them in the same cycle and popped once.
- R5: A write on the program port stores a route word. The program length becomes the highest written address plus one. The program counter advances by one on each commit and returns to zero after entry length-1. While the length is zero, no route executes.
- R6: Words from one source to one destination are delivered in the order they were accepted.
- R7: An input's `in_ready` is low while its FIFO holds FIFO_DEPTH words (default 2). A word offered while `in_ready` is low is not taken.
- R8: With no backpressure, each port accepts and delivers one word per cycle.
- R9: A word accepted on a processor input in cycle t appears on the destination tile's processor `out_valid` in cycle t+1+h, where h is the number of tile-to-tile hops. The consumer's register then holds it in cycle t+2+h.
- R10: An `out_valid` bit is only ever set while the matching `out_ready` bit is high, so each valid cycle is a completed transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | 5x32 | Input words, indexed N, E, S, W, P |
| in_valid | input | 5 | Input word present, per port |
| in_ready | output | 5 | Input FIFO has space, per port |
| out_data | output | 5x32 | Output words, indexed N, E, S, W, P |
| out_valid | output | 5 | Output transfer happens this cycle |
| out_ready | input | 5 | Receiver can take a word, per port |
| prog_we | input | 1 | Route memory write strobe |
| prog_addr | input | 4 | Route memory write address |
| prog_word | input | 15 | Route word to store |

## Verification
A word accepted at a rising edge reaches an output of the same tile in the very next cycle. A word crossing one hop reaches the far processor output two cycles after it was accepted. A stalled route word produces no output at all for as long as its missing source or blocked destination lasts. The bench drives inputs on the falling edge and samples one time unit later, so combinational outputs are read after they settle, in exactly the cycle the requirement gives. The streaming test uses pseudo-random backpressure and matches each delivered word against a count of the words accepted so far, which checks order without assuming a particular arrival cycle.

// File: rtl/smsw_pkg.sv
package smsw_pkg;
   localparam int NPORT   = 5;
   localparam int SEL_W   = 3;
   localparam int ROUTE_W = NPORT * SEL_W;

   typedef enum logic [SEL_W-1:0] {
      SRC_NONE = 3'd0,
      SRC_N    = 3'd1,
      SRC_E    = 3'd2,
      SRC_S    = 3'd3,
      SRC_W    = 3'd4,
      SRC_P    = 3'd5
   } src_sel_e;

   function automatic logic [SEL_W-1:0] route_field(input logic [ROUTE_W-1:0] rw, input int o);
      return rw[o*SEL_W +: SEL_W];
   endfunction
endpackage

// File: rtl/smsw_fifo.sv
module smsw_fifo #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   output logic              wr_ready,
   input  logic [DATA_W-1:0] wr_data,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   input  logic              rd_pop
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("smsw_fifo: DEPTH must be at least 2 for full throughput");
      end
   endgenerate

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PW-1:0]     wp, rp;
   logic [CW-1:0]     cnt;
   logic              push, pop;

   assign wr_ready = (cnt != CW'(DEPTH));
   assign rd_valid = (cnt != '0);
   assign rd_data  = mem[rp];
   assign push     = wr_valid & wr_ready;
   assign pop      = rd_pop & rd_valid;

   always_ff @(posedge clk) begin
      if (push) mem[wp] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + PW'(1);
         if (pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + PW'(1);
         case ({push, pop})
            2'b10:   cnt <= cnt + CW'(1);
            2'b01:   cnt <= cnt - CW'(1);
            default: cnt <= cnt;
         endcase
      end
   end

   // R3: the crossbar never pops an empty queue
   p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_pop |-> rd_valid);

   // R6: an unpopped head stays in place, so order is kept
   p_head_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_pop) |=> (rd_valid && rd_data == $past(rd_data)));
endmodule

// File: rtl/smsw_prog.sv
module smsw_prog
   import smsw_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH),
   localparam int LW   = AW + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [AW-1:0]      waddr,
   input  logic [ROUTE_W-1:0] wword,
   input  logic               advance,
   output logic [ROUTE_W-1:0] route,
   output logic               active
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("smsw_prog: DEPTH must be at least 2");
      end
   endgenerate

   logic [ROUTE_W-1:0] mem [DEPTH];
   logic [AW-1:0]      pc;
   logic [LW-1:0]      len;
   logic [LW-1:0]      wtop;

   assign wtop   = {1'b0, waddr} + LW'(1);
   assign active = (len != '0);
   assign route  = mem[pc];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wword;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc  <= '0;
         len <= '0;
      end else begin
         if (we && wtop > len) len <= wtop;
         if (advance) pc <= (LW'(pc) + LW'(1) == len) ? '0 : pc + AW'(1);
      end
   end

   // R5: the counter never leaves the loaded part of the program
   p_pc_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (LW'(pc) < len));

   // R5: nothing executes with an empty program
   p_idle_no_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> !advance);

   // R3: a stalled route word keeps its place
   p_pc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !advance |=> (pc == $past(pc)));
endmodule

// File: rtl/smsw_xbar.sv
module smsw_xbar
   import smsw_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter bit GATE_IDLE = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [ROUTE_W-1:0]            route,
   input  logic                          active,
   input  logic [NPORT-1:0][DATA_W-1:0]  head_data,
   input  logic [NPORT-1:0]              head_valid,
   input  logic [NPORT-1:0]              out_ready,
   output logic [NPORT-1:0]              pop,
   output logic [NPORT-1:0][DATA_W-1:0]  out_data,
   output logic [NPORT-1:0]              out_valid,
   output logic                          go
);
   logic [NPORT-1:0]             used;
   logic [NPORT-1:0][SEL_W-1:0]  src_idx;
   logic [NPORT-1:0]             need;
   logic [NPORT-1:0][DATA_W-1:0] muxed;
   logic                         src_ok, dst_ok;

   always_comb begin
      for (int o = 0; o < NPORT; o++) begin
         logic [SEL_W-1:0] f;
         f          = route_field(route, o);
         used[o]    = (f >= SRC_N) && (f <= SRC_P);
         src_idx[o] = f - SEL_W'(SRC_N);
      end
      for (int i = 0; i < NPORT; i++) begin
         need[i] = 1'b0;
         for (int o = 0; o < NPORT; o++) begin
            if (used[o] && src_idx[o] == SEL_W'(i)) need[i] = 1'b1;
         end
      end
   end

   assign src_ok = &(~need | head_valid);
   assign dst_ok = &(~used | out_ready);
   assign go     = active & src_ok & dst_ok;
   assign pop    = go ? need : '0;

   always_comb begin
      for (int o = 0; o < NPORT; o++) begin
         out_valid[o] = go & used[o];
         muxed[o]     = used[o] ? head_data[src_idx[o]] : '0;
      end
   end

   generate
      if (GATE_IDLE) begin : g_gated
         always_comb begin
            for (int o = 0; o < NPORT; o++)
               out_data[o] = out_valid[o] ? muxed[o] : '0;
         end
      end else begin : g_raw
         assign out_data = muxed;
      end
   endgenerate

   // R10: a valid output is always a completed transfer
   p_valid_needs_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid & ~out_ready) == '0);

   // R3: only queues holding a word are popped
   p_pop_has_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pop & ~head_valid) == '0);
endmodule

// File: rtl/static_mesh_switch.sv
module static_mesh_switch
   import smsw_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int FIFO_DEPTH = 2,
   parameter int PROG_DEPTH = 16,
   parameter bit GATE_IDLE  = 1'b1,
   localparam int PROG_AW   = $clog2(PROG_DEPTH)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NPORT-1:0][DATA_W-1:0] in_data,
   input  logic [NPORT-1:0]             in_valid,
   output logic [NPORT-1:0]             in_ready,
   output logic [NPORT-1:0][DATA_W-1:0] out_data,
   output logic [NPORT-1:0]             out_valid,
   input  logic [NPORT-1:0]             out_ready,
   input  logic                         prog_we,
   input  logic [PROG_AW-1:0]           prog_addr,
   input  logic [ROUTE_W-1:0]           prog_word
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("static_mesh_switch: DATA_W must be positive");
      end
   endgenerate

   logic [NPORT-1:0][DATA_W-1:0] head_data;
   logic [NPORT-1:0]             head_valid;
   logic [NPORT-1:0]             pop;
   logic [ROUTE_W-1:0]           route;
   logic                         active, go;

   generate
      for (genvar i = 0; i < NPORT; i++) begin : g_in
         smsw_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_valid (in_valid[i]),
            .wr_ready (in_ready[i]),
            .wr_data  (in_data[i]),
            .rd_valid (head_valid[i]),
            .rd_data  (head_data[i]),
            .rd_pop   (pop[i])
         );
      end
   endgenerate

   smsw_prog #(.DEPTH(PROG_DEPTH)) u_prog (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (prog_we),
      .waddr   (prog_addr),
      .wword   (prog_word),
      .advance (go),
      .route   (route),
      .active  (active)
   );

   smsw_xbar #(.DATA_W(DATA_W), .GATE_IDLE(GATE_IDLE)) u_xbar (
      .clk        (clk),
      .rst_n      (rst_n),
      .route      (route),
      .active     (active),
      .head_data  (head_data),
      .head_valid (head_valid),
      .out_ready  (out_ready),
      .pop        (pop),
      .out_data   (out_data),
      .out_valid  (out_valid),
      .go         (go)
   );

   // R1: leaving reset, every input queue is empty
   p_ready_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (in_ready == '1 && out_valid == '0));

   // R4: a pop always goes with at least one delivered word
   p_pop_delivers_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (|pop) |-> (|out_valid));
endmodule

// File: tb/test_static_mesh_switch.sv
module test_static_mesh_switch;
   localparam int CLK_PERIOD = 10;
   localparam int NP = 5;
   localparam int N_VEC = 5;
   localparam int N_STREAM = 24;

   // route word helper: fields in port order N,E,S,W,P from bit 0 upward
   function automatic logic [14:0] rw(input logic [2:0] n, e, s, w, p);
      return {p, w, s, e, n};
   endfunction

   localparam logic [14:0] V_ROUTE [N_VEC] = '{
      15'(5 << 0),                                   // P->N
      15'(4 << 12),                                  // W->P
      15'((3 << 0) | (3 << 9) | (3 << 12)),          // S->N,W,P
      15'(1 << 6),                                   // N->S
      15'((5 << 6) | (7 << 9) | (6 << 0))            // P->S, W and N codes unused
   };
   localparam int          V_SRC  [N_VEC] = '{4, 3, 2, 0, 4};
   localparam logic [4:0]  V_MASK [N_VEC] = '{5'b00001, 5'b10000, 5'b11001, 5'b00100, 5'b00100};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic [NP-1:0][31:0] tb_a_in_data, tb_b_in_data, a_in_data, b_in_data, a_out_data, b_out_data;
   logic [NP-1:0] tb_a_in_valid, tb_b_in_valid, a_in_valid, b_in_valid;
   logic [NP-1:0] tb_a_out_ready, tb_b_out_ready, a_out_ready, b_out_ready;
   logic [NP-1:0] a_in_ready, b_in_ready, a_out_valid, b_out_valid;
   logic          a_we, b_we;
   logic [3:0]    a_addr, b_addr;
   logic [14:0]   a_word, b_word;

   // A east link <-> B west link
   always_comb begin
      a_in_valid = tb_a_in_valid;  a_in_data = tb_a_in_data;  a_out_ready = tb_a_out_ready;
      b_in_valid = tb_b_in_valid;  b_in_data = tb_b_in_data;  b_out_ready = tb_b_out_ready;
      a_in_valid[1] = b_out_valid[3];  a_in_data[1] = b_out_data[3];  a_out_ready[1] = b_in_ready[3];
      b_in_valid[3] = a_out_valid[1];  b_in_data[3] = a_out_data[1];  b_out_ready[3] = a_in_ready[1];
   end

   static_mesh_switch i_static_mesh_switch (
      .clk(clk), .rst_n(rst_n),
      .in_data(a_in_data), .in_valid(a_in_valid), .in_ready(a_in_ready),
      .out_data(a_out_data), .out_valid(a_out_valid), .out_ready(a_out_ready),
      .prog_we(a_we), .prog_addr(a_addr), .prog_word(a_word));

   static_mesh_switch i_static_mesh_switch_east (
      .clk(clk), .rst_n(rst_n),
      .in_data(b_in_data), .in_valid(b_in_valid), .in_ready(b_in_ready),
      .out_data(b_out_data), .out_valid(b_out_valid), .out_ready(b_out_ready),
      .prog_we(b_we), .prog_addr(b_addr), .prog_word(b_word));

   int  n_checks = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic settle();
      #1;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      tb_a_in_valid = '0; tb_b_in_valid = '0; tb_a_in_data = '0; tb_b_in_data = '0;
      tb_a_out_ready = '1; tb_b_out_ready = '1;
      a_we = 1'b0; b_we = 1'b0; a_addr = '0; b_addr = '0; a_word = '0; b_word = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic load(input bit to_b, input logic [3:0] addr, input logic [14:0] w);
      @(negedge clk);
      if (to_b) begin b_we = 1'b1; b_addr = addr; b_word = w; end
      else      begin a_we = 1'b1; a_addr = addr; a_word = w; end
      @(negedge clk);
      a_we = 1'b0; b_we = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      tb_a_in_valid = '0; tb_b_in_valid = '0; tb_a_in_data = '0; tb_b_in_data = '0;
      tb_a_out_ready = '1; tb_b_out_ready = '1;
      a_we = 1'b0; b_we = 1'b0; a_addr = '0; b_addr = '0; a_word = '0; b_word = '0;

      // ---------------- table walk: one route word, one source word ----------------
      for (int v = 0; v < N_VEC; v++) begin
         logic [31:0] w;
         w = 32'hA000_0000 + 32'(v);
         do_reset();
         settle();
         check(a_in_ready == '1, "R1 in_ready after reset", 32'(a_in_ready), 32'h1f);
         check(a_out_valid == '0, "R1 out_valid after reset", 32'(a_out_valid), 32'h0);
         load(1'b0, 4'd0, V_ROUTE[v]);
         settle();
         check(a_out_valid == '0, "R3 stall without source word", 32'(a_out_valid), 32'h0);
         step();
         tb_a_in_valid[V_SRC[v]] = 1'b1;
         tb_a_in_data[V_SRC[v]]  = w;
         step();
         tb_a_in_valid = '0;
         settle();
         // accepted at the edge just passed: due now, 1+0 hops
         check((a_out_valid & 5'b11101) == V_MASK[v], "R2 R9 routed outputs",
               32'(a_out_valid), 32'(V_MASK[v]));
         for (int o = 0; o < NP; o++) begin
            if (V_MASK[v][o])
               check(a_out_data[o] == w, "R2 routed data", a_out_data[o], w);
         end
         step();
         settle();
         check(a_out_valid == '0, "R4 source popped once", 32'(a_out_valid), 32'h0);
      end

      // ---------------- empty program, full queue, late load ----------------
      do_reset();
      step();
      tb_a_in_valid[4] = 1'b1; tb_a_in_data[4] = 32'h1111_0001;
      step();
      tb_a_in_data[4] = 32'h1111_0002;
      settle();
      check(a_out_valid == '0, "R5 no route with empty program", 32'(a_out_valid), 32'h0);
      check(a_in_ready[4] == 1'b1, "R7 ready with one word", 32'(a_in_ready[4]), 32'h1);
      step();
      tb_a_in_data[4] = 32'h1111_0003;
      settle();
      check(a_in_ready[4] == 1'b0, "R7 ready low when full", 32'(a_in_ready[4]), 32'h0);
      step();
      tb_a_in_valid[4] = 1'b0;
      settle();
      check(a_out_valid == '0, "R5 still idle", 32'(a_out_valid), 32'h0);
      @(negedge clk);
      a_we = 1'b1; a_addr = 4'd0; a_word = rw(3'd5, 3'd0, 3'd0, 3'd0, 3'd0);
      @(negedge clk);
      a_we = 1'b0;
      settle();
      check(a_out_valid == 5'b00001 && a_out_data[0] == 32'h1111_0001, "R6 first queued word",
            a_out_data[0], 32'h1111_0001);
      step(); settle();
      check(a_out_valid == 5'b00001 && a_out_data[0] == 32'h1111_0002, "R6 second queued word",
            a_out_data[0], 32'h1111_0002);
      step(); settle();
      check(a_out_valid == '0, "R7 word offered while full not taken", 32'(a_out_valid), 32'h0);

      // ---------------- atomic commit ----------------
      do_reset();
      load(1'b0, 4'd0, rw(3'd5, 3'd0, 3'd4, 3'd0, 3'd0));   // P->N and W->S
      tb_a_out_ready[2] = 1'b0;
      step();
      tb_a_in_valid[4] = 1'b1; tb_a_in_data[4] = 32'hB0B0_0004;
      step();
      tb_a_in_valid = '0;
      settle();
      check(a_out_valid == '0, "R3 stall on missing source", 32'(a_out_valid), 32'h0);
      step();
      tb_a_in_valid[3] = 1'b1; tb_a_in_data[3] = 32'hB0B0_0003;
      step();
      tb_a_in_valid = '0;
      settle();
      check(a_out_valid == '0, "R3 R10 stall on blocked destination", 32'(a_out_valid), 32'h0);
      step();
      settle();
      check(a_out_valid == '0, "R3 stall holds", 32'(a_out_valid), 32'h0);
      step();
      tb_a_out_ready[2] = 1'b1;
      settle();
      check(a_out_valid == 5'b00101, "R3 both routes commit together", 32'(a_out_valid), 32'h5);
      check(a_out_data[0] == 32'hB0B0_0004 && a_out_data[2] == 32'hB0B0_0003, "R3 committed data",
            a_out_data[2], 32'hB0B0_0003);

      // ---------------- program order, wrap, throughput ----------------
      do_reset();
      load(1'b0, 4'd0, rw(3'd5, 3'd0, 3'd0, 3'd0, 3'd0));   // P->N
      load(1'b0, 4'd1, rw(3'd0, 3'd0, 3'd5, 3'd0, 3'd0));   // P->S
      load(1'b0, 4'd2, rw(3'd0, 3'd0, 3'd0, 3'd5, 3'd0));   // P->W
      for (int k = 0; k < 5; k++) begin
         step();
         if (k < 4) begin
            tb_a_in_valid[4] = 1'b1;
            tb_a_in_data[4]  = 32'h5EED_0000 + 32'(k);
         end else begin
            tb_a_in_valid[4] = 1'b0;
         end
         settle();
         if (k < 4)
            check(a_in_ready[4] == 1'b1, "R8 input keeps up", 32'(a_in_ready[4]), 32'h1);
         if (k > 0) begin
            int port;
            port = ((k - 1) % 3 == 0) ? 0 : (((k - 1) % 3 == 1) ? 2 : 3);
            check(a_out_valid == 5'(1 << port), "R5 R8 sequence and wrap",
                  32'(a_out_valid), 32'(1 << port));
            check(a_out_data[port] == 32'h5EED_0000 + 32'(k - 1), "R5 sequence data",
                  a_out_data[port], 32'h5EED_0000 + 32'(k - 1));
         end
      end

      // ---------------- two-tile chain: latency and ordering ----------------
      do_reset();
      load(1'b0, 4'd0, rw(3'd0, 3'd5, 3'd0, 3'd0, 3'd0));   // A: P->E
      load(1'b1, 4'd0, rw(3'd0, 3'd0, 3'd0, 3'd0, 3'd4));   // B: W->P
      step();
      tb_a_in_valid[4] = 1'b1; tb_a_in_data[4] = 32'h7A7E_0001;
      step();                                               // accepted at edge ending cycle t
      tb_a_in_valid[4] = 1'b0;
      settle();
      check(b_out_valid[4] == 1'b0, "R9 not yet at t+1", 32'(b_out_valid[4]), 32'h0);
      step();
      settle();
      check(b_out_valid[4] == 1'b1 && b_out_data[4] == 32'h7A7E_0001, "R9 arrives at t+2 after one hop",
            b_out_data[4], 32'h7A7E_0001);
      begin
         int  sent = 0;
         int  recv = 0;
         logic [7:0] lfsr = 8'h5A;
         for (int c = 0; c < 600 && recv < N_STREAM; c++) begin
            step();
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            tb_b_out_ready[4] = lfsr[0] | lfsr[2];
            tb_a_in_valid[4]  = (sent < N_STREAM) && lfsr[1];
            tb_a_in_data[4]   = 32'hC0DE_0000 + 32'(sent);
            settle();
            if (tb_a_in_valid[4] && a_in_ready[4]) sent++;
            if (b_out_valid[4]) begin
               check(b_out_data[4] == 32'hC0DE_0000 + 32'(recv), "R6 order across chain",
                     b_out_data[4], 32'hC0DE_0000 + 32'(recv));
               check(tb_b_out_ready[4] == 1'b1, "R10 valid only with ready", 32'(tb_b_out_ready[4]), 32'h1);
               recv++;
            end
         end
         tb_a_in_valid = '0;
         check(recv == N_STREAM, "R6 all streamed words delivered", 32'(recv), 32'(N_STREAM));
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule